// File: doc/BRIEF.md
# Completed Reference Ordered Buffer

This block sits beside one processor's load/store pipeline. It records every memory reference as it completes and keeps only the most recent reference to each word address. Each record carries an ordering-point tag. The tag is the number of this processor's completed stores that must be reached before the reference counts as globally ordered.

A completing load takes its tag from the closest older reference already held. A completing store takes the larger of that inherited tag and the tag handed to it by the coherence reply. It then raises the tag of any younger load already in the buffer. When a remote invalidation arrives, it carries the remote processor's completed-store count. The block looks up the invalidated word, and if the stored tag is strictly larger than that count, it reports an ordering violation. The report names both the local and the remote instruction addresses.

Serial numbers and tags are compared wrap-aware. The buffer is circular: when every slot has been written, the oldest slot is overwritten. An invalidation lookup takes the cycle, and an insert offered in that cycle is refused.

Top module: `crob_top`

## Requirements
- R1: After synchronous active-low reset, the buffer holds no entries, `look_hit` and `viol_valid` are 0 and `ins_ready` is 1.
- R2: An invalidation sets `look_hit` to 1 in the next cycle if a held entry has the same word address, and to 0 otherwise. A miss never reports a violation. `look_hit` is 0 in any cycle that does not follow an invalidation.
- R3: Inserting a reference removes any older entry with the same word address, so a lookup returns the newest reference to that address.
- R4: In the cycle after an invalidation hits, `viol_valid` is 1 only if the entry's tag is strictly greater than `inv_count`, with `viol_local_iaddr` set to the entry's instruction address and `viol_remote_iaddr` set to `inv_iaddr`. `viol_valid` lasts one cycle.
- R5: An inserted load (`ins_store`=0) gets the tag of the held entry with the latest serial number older than its own, or 0 if there is none.
- R6: An inserted store (`ins_store`=1) gets the larger of `ins_tag` and the tag it would inherit as a load.
- R7: When a store is inserted, every held load with a younger serial number whose tag is smaller takes the store's tag.
- R8: With DEPTH slots written, the next insert overwrites the oldest written slot, and that entry is no longer found by lookup.
- R9: A serial number or tag a is later than b when a > b, except that when the top bits of a and b differ the numerically smaller one is the later.
- R10: While `inv_valid` is 1, `ins_ready` is 0 and an offered insert is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | A completed reference is offered |
| ins_ready | output | 1 | Insert accepted this cycle |
| ins_sn | input | SNW | Serial number of the reference |
| ins_addr | input | AW | Word address |
| ins_iaddr | input | IW | Instruction address |
| ins_store | input | 1 | 1 = store, 0 = load |
| ins_tag | input | TW | Tag received for a store |
| inv_valid | input | 1 | Remote invalidation present |
| inv_addr | input | AW | Invalidated word address |
| inv_count | input | TW | Remote completed-store count |
| inv_iaddr | input | IW | Remote store instruction address |
| look_hit | output | 1 | Lookup of previous cycle hit |
| viol_valid | output | 1 | Violation pulse |
| viol_local_iaddr | output | IW | Instruction address of the matched entry |
| viol_remote_iaddr | output | IW | Instruction address of the remote store |

## Verification
A wrong tag stays hidden until an invalidation reaches that word. It then shows as a missing or spurious `viol_valid` one cycle later. The bench therefore probes counts on both sides of every expected tag, one below and one equal. A wrong valid bit or a deduplication fault shows as a wrong `look_hit`, or as a `viol_local_iaddr` naming a stale instruction in the cycle after the lookup. Eviction and serial-number wrap faults surface only after the buffer fills, or after serials straddle the top bit, so directed cases build both conditions.

// File: rtl/crob_pkg.sv
// Shared helpers for the completed reference buffer.
// Assumes all ordered quantities are no wider than 32 bits.
package crob_pkg;
    // Wrap-aware ordering: returns 1 when a is later than b at width w.
    function automatic logic later_than(input logic [31:0] a, input logic [31:0] b, input int w);
        logic ma, mb;
        ma = a[w-1];
        mb = b[w-1];
        return (ma != mb) ? (a < b) : (a > b);
    endfunction
endpackage

// File: rtl/crob_match.sv
// Associative address compare across all slots.
// Produces a hit vector; only valid slots can hit.
module crob_match #(
    parameter int DEPTH = 32,
    parameter int AW    = 16
) (
    input  logic [DEPTH-1:0] vld,
    input  logic [AW-1:0]    addr [DEPTH],
    input  logic [AW-1:0]    key,
    output logic [DEPTH-1:0] hit
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        // one comparator per slot
        assign hit[i] = vld[i] && (addr[i] == key);
    end
endmodule

// File: rtl/crob_pick.sv
// Finds the tag of the held entry whose serial number is the latest
// one still older than key_sn. Returns 0 when no entry is older.
// Assumes serial numbers of held entries are distinct.
module crob_pick #(
    parameter int DEPTH = 32,
    parameter int SNW   = 8,
    parameter int TW    = 8
) (
    input  logic [DEPTH-1:0] vld,
    input  logic [SNW-1:0]   sn  [DEPTH],
    input  logic [TW-1:0]    tag [DEPTH],
    input  logic [SNW-1:0]   key_sn,
    output logic [TW-1:0]    tag_out
);
    import crob_pkg::*;

    // linear search for the nearest older entry
    always_comb begin
        logic           found;
        logic [SNW-1:0] best_sn;
        found   = 1'b0;
        best_sn = '0;
        tag_out = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && later_than(32'(key_sn), 32'(sn[i]), SNW) &&
                (!found || later_than(32'(sn[i]), 32'(best_sn), SNW))) begin
                found   = 1'b1;
                best_sn = sn[i];
                tag_out = tag[i];
            end
        end
    end
endmodule

// File: rtl/crob_top.sv
// Completed reference buffer for one processor.
// Circular slots written in completion order; one entry per word address;
// tags inherited by loads and pushed to younger loads by stores; remote
// invalidations checked for ordering violations with a one-cycle result.
// Assumes callers present distinct serial numbers among held entries.
module crob_top #(
    parameter int DEPTH = 32,
    parameter int SNW   = 8,
    parameter int AW    = 16,
    parameter int IW    = 16,
    parameter int TW    = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ins_valid,
    output logic           ins_ready,
    input  logic [SNW-1:0] ins_sn,
    input  logic [AW-1:0]  ins_addr,
    input  logic [IW-1:0]  ins_iaddr,
    input  logic           ins_store,
    input  logic [TW-1:0]  ins_tag,
    input  logic           inv_valid,
    input  logic [AW-1:0]  inv_addr,
    input  logic [TW-1:0]  inv_count,
    input  logic [IW-1:0]  inv_iaddr,
    output logic           look_hit,
    output logic           viol_valid,
    output logic [IW-1:0]  viol_local_iaddr,
    output logic [IW-1:0]  viol_remote_iaddr
);
    import crob_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DEPTH-1:0] e_vld;
    logic [DEPTH-1:0] e_st;
    logic [SNW-1:0]   e_sn    [DEPTH];
    logic [AW-1:0]    e_addr  [DEPTH];
    logic [IW-1:0]    e_iaddr [DEPTH];
    logic [TW-1:0]    e_tag   [DEPTH];
    logic [PW-1:0]    wr_ptr;

    logic [DEPTH-1:0] inv_vec;
    logic [DEPTH-1:0] dup_vec;
    logic [TW-1:0]    prev_tag;
    logic [TW-1:0]    new_tag;
    logic [TW-1:0]    sel_tag;
    logic [IW-1:0]    sel_iaddr;
    logic             ins_fire;

    crob_match #(.DEPTH(DEPTH), .AW(AW)) u_inv_match (
        .vld(e_vld), .addr(e_addr), .key(inv_addr), .hit(inv_vec)
    );

    crob_match #(.DEPTH(DEPTH), .AW(AW)) u_dup_match (
        .vld(e_vld), .addr(e_addr), .key(ins_addr), .hit(dup_vec)
    );

    crob_pick #(.DEPTH(DEPTH), .SNW(SNW), .TW(TW)) u_pick (
        .vld(e_vld), .sn(e_sn), .tag(e_tag), .key_sn(ins_sn), .tag_out(prev_tag)
    );

    // invalidation owns the cycle; inserts wait
    assign ins_ready = !inv_valid;
    assign ins_fire  = ins_valid && ins_ready;

    // store tag is the later of received and inherited
    always_comb begin
        new_tag = prev_tag;
        if (ins_store && later_than(32'(ins_tag), 32'(prev_tag), TW))
            new_tag = ins_tag;
    end

    // mux out the single matching entry for the lookup
    always_comb begin
        sel_tag   = '0;
        sel_iaddr = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (inv_vec[i]) begin
                sel_tag   = sel_tag | e_tag[i];
                sel_iaddr = sel_iaddr | e_iaddr[i];
            end
        end
    end

    // valid bits, write pointer and lookup results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_vld             <= '0;
            wr_ptr            <= '0;
            look_hit          <= 1'b0;
            viol_valid        <= 1'b0;
            viol_local_iaddr  <= '0;
            viol_remote_iaddr <= '0;
        end else begin
            look_hit          <= inv_valid && (|inv_vec);
            viol_valid        <= inv_valid && (|inv_vec) &&
                                 later_than(32'(sel_tag), 32'(inv_count), TW);
            viol_local_iaddr  <= sel_iaddr;
            viol_remote_iaddr <= inv_iaddr;
            if (ins_fire) begin
                e_vld         <= e_vld & ~dup_vec;
                e_vld[wr_ptr] <= 1'b1;
                wr_ptr        <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
        end
    end

    // entry payloads and tag back-propagation to younger loads
    always_ff @(posedge clk) begin
        if (ins_fire) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ins_store && e_vld[i] && !e_st[i] &&
                    later_than(32'(e_sn[i]), 32'(ins_sn), SNW) &&
                    later_than(32'(new_tag), 32'(e_tag[i]), TW))
                    e_tag[i] <= new_tag;
            end
            e_sn[wr_ptr]    <= ins_sn;
            e_addr[wr_ptr]  <= ins_addr;
            e_iaddr[wr_ptr] <= ins_iaddr;
            e_st[wr_ptr]    <= ins_store;
            e_tag[wr_ptr]   <= new_tag;
        end
    end
endmodule

// File: rtl/crob_chk.sv
// Temporal checks on the completed reference buffer, bound to crob_top.
module crob_chk #(
    parameter int DEPTH = 32,
    parameter int IW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inv_valid,
    input logic [IW-1:0]    inv_iaddr,
    input logic [DEPTH-1:0] inv_vec,
    input logic             look_hit,
    input logic             viol_valid,
    input logic [IW-1:0]    viol_remote_iaddr
);
    p_dedup_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inv_vec));

    p_hit_after_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        look_hit |-> $past(inv_valid));

    p_no_hit_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_valid |=> !look_hit);

    p_viol_has_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> look_hit);

    p_remote_iaddr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (viol_remote_iaddr == $past(inv_iaddr)));
endmodule

bind crob_top crob_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (.*);

// File: tb/sim_crob_top.sv
// Bench for crob_top: table-driven main sequence, then directed cases.
module sim_crob_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0, ins_store = 1'b0, inv_valid = 1'b0;
    logic [7:0]  ins_sn = '0, ins_tag = '0, inv_count = '0;
    logic [15:0] ins_addr = '0, ins_iaddr = '0, inv_addr = '0, inv_iaddr = '0;
    logic        ins_ready, look_hit, viol_valid;
    logic [15:0] viol_local_iaddr, viol_remote_iaddr;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    crob_top u0 (.*);

    typedef struct packed {
        logic        inv;
        logic [7:0]  sn;
        logic [15:0] addr;
        logic [15:0] iaddr;  // insert: own iaddr; lookup: expected local iaddr
        logic        st;
        logic [7:0]  tv;     // insert: received tag; lookup: remote count
        logic        hit;
        logic        viol;
    } vec_t;

    localparam vec_t TBL [16] = '{
        '{1'b0, 8'd1, 16'h10, 16'hA0, 1'b1, 8'd0,  1'b0, 1'b0},
        '{1'b0, 8'd3, 16'h20, 16'hA1, 1'b0, 8'd0,  1'b0, 1'b0},
        '{1'b0, 8'd4, 16'h30, 16'hA2, 1'b1, 8'd11, 1'b0, 1'b0},
        '{1'b0, 8'd2, 16'h40, 16'hA3, 1'b1, 8'd9,  1'b0, 1'b0},
        '{1'b1, 8'd0, 16'h20, 16'hA1, 1'b0, 8'd8,  1'b1, 1'b1}, // R7 pushed tag 9
        '{1'b1, 8'd0, 16'h20, 16'hA1, 1'b0, 8'd9,  1'b1, 1'b0}, // R4 equal: none
        '{1'b1, 8'd0, 16'h30, 16'hA2, 1'b0, 8'd10, 1'b1, 1'b1}, // R6 tag 11
        '{1'b1, 8'd0, 16'h55, 16'h00, 1'b0, 8'd0,  1'b0, 1'b0}, // R2 miss
        '{1'b0, 8'd5, 16'h20, 16'hA5, 1'b0, 8'd0,  1'b0, 1'b0},
        '{1'b1, 8'd0, 16'h20, 16'hA5, 1'b0, 8'd10, 1'b1, 1'b1}, // R3 R5
        '{1'b0, 8'd7, 16'h80, 16'hA7, 1'b1, 8'd3,  1'b0, 1'b0},
        '{1'b1, 8'd0, 16'h80, 16'hA7, 1'b0, 8'd10, 1'b1, 1'b1}, // R6 inherited 11
        '{1'b1, 8'd0, 16'h80, 16'hA7, 1'b0, 8'd11, 1'b1, 1'b0}, // R4
        '{1'b1, 8'd0, 16'h10, 16'hA0, 1'b0, 8'd0,  1'b1, 1'b0}, // R2 hit
        '{1'b0, 8'd6, 16'h60, 16'hA6, 1'b0, 8'd0,  1'b0, 1'b0},
        '{1'b1, 8'd0, 16'h60, 16'hA6, 1'b0, 8'd10, 1'b1, 1'b1}  // R5 from sn5
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_ins(input logic [7:0] sn, input logic [15:0] a, input logic [15:0] ia,
                          input logic st, input logic [7:0] tg);
        @(negedge clk);
        ins_valid = 1'b1; ins_sn = sn; ins_addr = a; ins_iaddr = ia;
        ins_store = st; ins_tag = tg;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    // results registered at the posedge are sampled at the following negedge
    task automatic do_inv(input logic [15:0] a, input logic [7:0] cnt, input string req,
                          input logic eh, input logic ev, input logic [15:0] eia);
        @(negedge clk);
        inv_valid = 1'b1; inv_addr = a; inv_count = cnt; inv_iaddr = 16'hBEEF;
        @(negedge clk);
        inv_valid = 1'b0;
        chk(look_hit == eh, req, look_hit, eh);
        chk(viol_valid == ev, req, viol_valid, ev);
        if (ev) begin
            chk(viol_local_iaddr == eia, req, viol_local_iaddr, eia);
            chk(viol_remote_iaddr == 16'hBEEF, req, viol_remote_iaddr, 16'hBEEF);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(look_hit == 1'b0 && viol_valid == 1'b0, "R1", {look_hit, viol_valid}, 0);
        chk(ins_ready == 1'b1, "R1", ins_ready, 1);
        rst_n = 1'b1;

        for (int k = 0; k < 16; k++) begin
            if (TBL[k].inv)
                do_inv(TBL[k].addr, TBL[k].tv, "R2/R4 table", TBL[k].hit, TBL[k].viol, TBL[k].iaddr);
            else
                do_ins(TBL[k].sn, TBL[k].addr, TBL[k].iaddr, TBL[k].st, TBL[k].tv);
        end

        // R4 pulse lasts one cycle
        do_inv(16'h60, 8'd10, "R4", 1'b1, 1'b1, 16'hA6);
        @(negedge clk);
        chk(viol_valid == 1'b0, "R4 pulse", viol_valid, 0);
        chk(look_hit == 1'b0, "R2 idle", look_hit, 0);

        // R1 reset empties the buffer
        do_reset();
        do_inv(16'h20, 8'd0, "R1 empty", 1'b0, 1'b0, 16'h0);

        // R5 load with no older entry gets tag 0
        do_ins(8'd1, 16'h70, 16'hC0, 1'b0, 8'd0);
        do_inv(16'h70, 8'd0, "R5 zero", 1'b1, 1'b0, 16'h0);

        // R9 serial wrap: 3 is later than 250
        do_reset();
        do_ins(8'd250, 16'h1, 16'hB1, 1'b1, 8'd7);
        do_ins(8'd3, 16'h2, 16'hB2, 1'b0, 8'd0);
        do_inv(16'h2, 8'd5, "R9", 1'b1, 1'b1, 16'hB2);

        // R10 lookup wins, insert dropped
        @(negedge clk);
        ins_valid = 1'b1; ins_sn = 8'd9; ins_addr = 16'h99; ins_iaddr = 16'hD9;
        ins_store = 1'b0;
        inv_valid = 1'b1; inv_addr = 16'h2; inv_count = 8'd7; inv_iaddr = 16'hBEEF;
        #1;
        chk(ins_ready == 1'b0, "R10 ready", ins_ready, 0);
        @(negedge clk);
        ins_valid = 1'b0; inv_valid = 1'b0;
        chk(look_hit == 1'b1, "R10 lookup", look_hit, 1);
        do_inv(16'h99, 8'd0, "R10 dropped", 1'b0, 1'b0, 16'h0);

        // R8 eviction of the oldest slot
        do_reset();
        do_ins(8'd1, 16'h100, 16'hE0, 1'b1, 8'd5);
        for (int k = 0; k < 32; k++)
            do_ins(8'(2 + k), 16'(16'h200 + k), 16'(16'hE100 + k), 1'b0, 8'd0);
        do_inv(16'h100, 8'd0, "R8 evicted", 1'b0, 1'b0, 16'h0);
        do_inv(16'h200, 8'd4, "R8 kept", 1'b1, 1'b1, 16'hE100);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule